// File: doc/BRIEF.md
# 8b/10b Transmit Encoder with Control Characters

This block turns one byte per clock into a 10-bit DC-balanced transmission word and keeps the running disparity (RD) from word to word. A flag marks a byte as a control character. The byte is checked against a fixed set of legal control values. An illegal one is flagged and replaced by the comma character K28.5. One extra control value stands for an error code and produces a deliberately illegal but neutral word. When no byte is offered, the block can fill the gap with K28.5 on request.

Each word passes through a fixed three-stage pipeline. The disparity that the final stage starts from can be overridden combinationally, and the disparity that results from the word in that stage is also brought out combinationally. Because of these two paths, two copies can be chained so that a 16-bit word is encoded as one 20-bit unit. The high byte goes first, and the low byte starts from the disparity the high byte leaves.

Top module: `tx_8b10b_enc`

## Requirements
- R1: Data bytes (control flag low) are encoded with the standard 5b/6b and 3b/4b tables. Byte bit 0 is A, bits 4:0 form the 5-bit group x and bits 7:5 form the 3-bit group y. Code bit k follows the order a,b,c,d,e,i,f,g,h,j for k = 0..9, bit 0 is sent first, and different bytes never produce the same word.
- R2: RD is 0 for negative and 1 for positive, and resets to negative. A word with five ones leaves RD unchanged and a word with four or six ones flips it. A six-one word is only sent from negative RD and a four-one word only from positive RD.
- R3: For D.x.7, the alternate sub-block 0111/1000 is used when RD is negative and x is 17, 18 or 20, or when RD is positive and x is 11, 13 or 14. No stream of data words has a run of more than five equal bits.
- R4: With the control flag set, the valid control bytes are K28.0 to K28.7 (x = 28, any y), K23.7, K27.7, K29.7 and K30.7 (y = 7 with x = 23, 27, 29 or 30), and the error code 8'hFF. The first twelve of these are encoded as the standard control characters.
- R5: A byte with the control flag set that is not one of the thirteen valid values raises the error flag, which is aligned with its word, and is sent as K28.5 for the current RD.
- R6: The error code 8'hFF sends abcdei fghj = 001111 0001 at negative RD and 110000 1110 at positive RD. It leaves RD unchanged and does not raise the error flag.
- R7: With enable low and idle request high, K28.5 is sent with valid high. With both low, valid is low, and the code word and RD hold their values.
- R8: Inputs sampled at rising edge n give a result that is visible after edge n+2 and is sampled at edge n+3. Valid is still low at the sample point one cycle earlier.
- R9: While force is high, the rd input replaces the stored RD for the word in the final stage. The force and rd inputs are unpipelined and are sampled two cycles after their data.
- R10: The cascade output is, combinationally, the RD that results from encoding the word in the final stage from the effective input RD. Two copies can be chained (high cascade output to low rd input, low rd output to high rd input, both forces high), and the low byte then starts from the RD of the high byte.
- R11: After reset the code is all zeros and valid, the error flag and RD are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to encode, bit 0 = A |
| ctrl_i | input | 1 | Byte is a control character |
| en_i | input | 1 | A byte is offered this cycle |
| idle_i | input | 1 | Send K28.5 when no byte is offered |
| rd_force_i | input | 1 | Use rd_i instead of the stored RD (unpipelined) |
| rd_i | input | 1 | Override RD, 0 = negative |
| code_o | output | 10 | Encoded word, bit 0 = a, sent first |
| valid_o | output | 1 | code_o holds a new word |
| kerr_o | output | 1 | Illegal control byte was replaced |
| rd_o | output | 1 | RD after the word on code_o |
| rd_cas_o | output | 1 | RD after the final-stage word, combinational |

## Verification
The bench goes after the words whose sub-block choice is least obvious: the neutral-but-alternating D.7 and x.3 groups, the alternate x.7 sub-block, the K28 fourth sub-blocks that differ from data, and the error code. A wrong table or choice rule sends a word with the wrong polarity or a run that is too long, and known-word checks plus a sweep of all 256 bytes expose this. The override is tested with a value that disagrees with the stored RD, so a design that ignores force, or samples it in the wrong stage, sends the opposite polarity. A chained pair checks that the low byte takes the disparity the high byte leaves, and not a stale one. Illegal control bytes, idle filling and an enable-low gap are checked for the error flag, for K28.5, and for code and RD holding.

// File: rtl/tx8b10b_pkg.sv
package tx8b10b_pkg;

    localparam int BYTE_W = 8;
    localparam int XW     = 5;
    localparam int YW     = 3;
    localparam int SIX_W  = 6;
    localparam int FOUR_W = 4;
    localparam int CODE_W = SIX_W + FOUR_W;

    localparam logic [XW-1:0]     K28_X   = 5'd28;
    localparam logic [BYTE_W-1:0] COMMA_B = 8'hBC;
    localparam logic [BYTE_W-1:0] ERRC_B  = 8'hFF;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_DATA = 2'd1,
        KIND_CTRL = 2'd2,
        KIND_ERRC = 2'd3
    } kind_e;

    // 6-bit sub-block for negative RD, written a..i from MSB to LSB
    function automatic logic [SIX_W-1:0] six_neg(input logic [XW-1:0] x);
        case (x)
            5'd0:  return 6'b100111;
            5'd1:  return 6'b011101;
            5'd2:  return 6'b101101;
            5'd3:  return 6'b110001;
            5'd4:  return 6'b110101;
            5'd5:  return 6'b101001;
            5'd6:  return 6'b011001;
            5'd7:  return 6'b111000;
            5'd8:  return 6'b111001;
            5'd9:  return 6'b100101;
            5'd10: return 6'b010101;
            5'd11: return 6'b110100;
            5'd12: return 6'b001101;
            5'd13: return 6'b101100;
            5'd14: return 6'b011100;
            5'd15: return 6'b010111;
            5'd16: return 6'b011011;
            5'd17: return 6'b100011;
            5'd18: return 6'b010011;
            5'd19: return 6'b110010;
            5'd20: return 6'b001011;
            5'd21: return 6'b101010;
            5'd22: return 6'b011010;
            5'd23: return 6'b111010;
            5'd24: return 6'b110011;
            5'd25: return 6'b100110;
            5'd26: return 6'b010110;
            5'd27: return 6'b110110;
            5'd28: return 6'b001110;
            5'd29: return 6'b101110;
            5'd30: return 6'b011110;
            default: return 6'b101011;
        endcase
    endfunction

    // 4-bit sub-block for data, negative RD into the sub-block, f..j MSB to LSB
    function automatic logic [FOUR_W-1:0] four_dat(input logic [YW-1:0] y);
        case (y)
            3'd0: return 4'b1011;
            3'd1: return 4'b1001;
            3'd2: return 4'b0101;
            3'd3: return 4'b1100;
            3'd4: return 4'b1101;
            3'd5: return 4'b1010;
            3'd6: return 4'b0110;
            default: return 4'b1110;
        endcase
    endfunction

    // 4-bit sub-block for control characters, negative RD into the sub-block
    function automatic logic [FOUR_W-1:0] four_ctl(input logic [YW-1:0] y);
        case (y)
            3'd0: return 4'b1011;
            3'd1: return 4'b0110;
            3'd2: return 4'b1010;
            3'd3: return 4'b1100;
            3'd4: return 4'b1101;
            3'd5: return 4'b0101;
            3'd6: return 4'b1001;
            default: return 4'b0111;
        endcase
    endfunction

    // MSB-first transmission string to port order (bit 0 sent first)
    function automatic logic [CODE_W-1:0] to_port(input logic [CODE_W-1:0] w);
        logic [CODE_W-1:0] r;
        for (int k = 0; k < CODE_W; k++) r[k] = w[CODE_W-1-k];
        return r;
    endfunction

endpackage

// File: rtl/tx_ctrl_classify.sv
module tx_ctrl_classify
    import tx8b10b_pkg::*;
(
    input  logic              en_i,
    input  logic              idle_i,
    input  logic              ctrl_i,
    input  logic [BYTE_W-1:0] dat_i,
    output kind_e             kind_o,
    output logic [BYTE_W-1:0] dat_o,
    output logic              err_o
);
    logic [XW-1:0] x;
    logic [YW-1:0] y;
    logic          is_k28;
    logic          is_kx7;
    logic          is_errc;

    assign x       = dat_i[XW-1:0];
    assign y       = dat_i[BYTE_W-1:XW];
    assign is_k28  = (x == K28_X);
    assign is_kx7  = (y == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30);
    assign is_errc = (dat_i == ERRC_B);

    always_comb begin
        kind_o = KIND_NONE;
        dat_o  = dat_i;
        err_o  = 1'b0;
        if (en_i) begin
            if (!ctrl_i) begin
                kind_o = KIND_DATA;
            end else if (is_errc) begin
                kind_o = KIND_ERRC;
            end else if (is_k28 || is_kx7) begin
                kind_o = KIND_CTRL;
            end else begin
                kind_o = KIND_CTRL;
                dat_o  = COMMA_B;
                err_o  = 1'b1;
            end
        end else if (idle_i) begin
            kind_o = KIND_CTRL;
            dat_o  = COMMA_B;
        end
    end
endmodule

// File: rtl/tx_code_build.sv
module tx_code_build
    import tx8b10b_pkg::*;
(
    input  kind_e             kind_i,
    input  logic [BYTE_W-1:0] dat_i,
    input  logic              rd_i,
    output logic [CODE_W-1:0] code_o,
    output logic              rd_o
);
    logic [XW-1:0]     x;
    logic [YW-1:0]     y;
    logic [SIX_W-1:0]  six_base;
    logic [SIX_W-1:0]  six_sel;
    logic [FOUR_W-1:0] four_base;
    logic [FOUR_W-1:0] four_sel;
    logic              six_heavy;
    logic              six_alt;
    logic              four_heavy;
    logic              four_alt;
    logic              rd_mid;
    logic              use_a7;
    logic              is_ctl;

    assign x      = dat_i[XW-1:0];
    assign y      = dat_i[BYTE_W-1:XW];
    assign is_ctl = (kind_i == KIND_CTRL);

    always_comb begin
        six_base   = (is_ctl && x == K28_X) ? 6'b001111 : six_neg(x);
        six_heavy  = ($countones(six_base) != 3);
        six_alt    = six_heavy || (six_base == 6'b111000);
        six_sel    = (rd_i && six_alt) ? ~six_base : six_base;
        rd_mid     = rd_i ^ six_heavy;

        use_a7     = (y == 3'd7) &&
                     ((!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                      ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
        if (is_ctl) begin
            four_base = four_ctl(y);
            four_alt  = 1'b1;
        end else begin
            four_base = use_a7 ? 4'b0111 : four_dat(y);
            four_alt  = ($countones(four_base) != 2) || (y == 3'd3);
        end
        four_heavy = ($countones(four_base) != 2);
        four_sel   = (rd_mid && four_alt) ? ~four_base : four_base;

        code_o = to_port({six_sel, four_sel});
        rd_o   = rd_mid ^ four_heavy;

        if (kind_i == KIND_ERRC) begin
            code_o = rd_i ? to_port(10'b110000_1110) : to_port(10'b001111_0001);
            rd_o   = rd_i;
        end else if (kind_i == KIND_NONE) begin
            rd_o   = rd_i;
        end
    end
endmodule

// File: rtl/tx_8b10b_enc.sv
module tx_8b10b_enc
    import tx8b10b_pkg::*;
#(
    parameter logic RESET_RD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              ctrl_i,
    input  logic              en_i,
    input  logic              idle_i,
    input  logic              rd_force_i,
    input  logic              rd_i,
    output logic [CODE_W-1:0] code_o,
    output logic              valid_o,
    output logic              kerr_o,
    output logic              rd_o,
    output logic              rd_cas_o
);
    typedef struct packed {
        logic              en;
        logic              idle;
        logic              ctrl;
        logic [BYTE_W-1:0] dat;
    } in_stg_t;

    typedef struct packed {
        kind_e             kind;
        logic [BYTE_W-1:0] dat;
        logic              err;
    } cls_stg_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              valid;
        logic              err;
        logic              rd;
    } out_stg_t;

    typedef struct packed {
        in_stg_t  s1;
        cls_stg_t s2;
        out_stg_t o;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    kind_e             cls_kind;
    logic [BYTE_W-1:0] cls_dat;
    logic              cls_err;
    logic              rd_eff;
    logic [CODE_W-1:0] bld_code;
    logic              bld_rd;

    tx_ctrl_classify u_cls (
        .en_i   (pipe_q.s1.en),
        .idle_i (pipe_q.s1.idle),
        .ctrl_i (pipe_q.s1.ctrl),
        .dat_i  (pipe_q.s1.dat),
        .kind_o (cls_kind),
        .dat_o  (cls_dat),
        .err_o  (cls_err)
    );

    assign rd_eff = rd_force_i ? rd_i : pipe_q.o.rd;

    tx_code_build u_bld (
        .kind_i (pipe_q.s2.kind),
        .dat_i  (pipe_q.s2.dat),
        .rd_i   (rd_eff),
        .code_o (bld_code),
        .rd_o   (bld_rd)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s1.en   = en_i;
        pipe_d.s1.idle = idle_i;
        pipe_d.s1.ctrl = ctrl_i;
        pipe_d.s1.dat  = data_i;
        pipe_d.s2.kind = cls_kind;
        pipe_d.s2.dat  = cls_dat;
        pipe_d.s2.err  = cls_err;
        pipe_d.o.rd    = bld_rd;
        if (pipe_q.s2.kind != KIND_NONE) begin
            pipe_d.o.code  = bld_code;
            pipe_d.o.valid = 1'b1;
            pipe_d.o.err   = pipe_q.s2.err;
        end else begin
            pipe_d.o.valid = 1'b0;
            pipe_d.o.err   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q      <= '0;
            pipe_q.o.rd <= RESET_RD;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign code_o   = pipe_q.o.code;
    assign valid_o  = pipe_q.o.valid;
    assign kerr_o   = pipe_q.o.err;
    assign rd_o     = pipe_q.o.rd;
    assign rd_cas_o = bld_rd;
endmodule

// File: rtl/tx_8b10b_enc_chk.sv
module tx_8b10b_enc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_force_i,
    input logic [9:0] code_o,
    input logic       valid_o,
    input logic       kerr_o,
    input logic       rd_o
);
    // K28.5 in port order for negative and positive RD
    localparam logic [9:0] COMMA_NEG = 10'b0101111100;
    localparam logic [9:0] COMMA_POS = 10'b1010000011;

    p_err_sends_comma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kerr_o |-> (valid_o && (code_o == COMMA_NEG || code_o == COMMA_POS)));

    p_ones_band_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($countones(code_o) >= 4 && $countones(code_o) <= 6));

    p_neutral_keeps_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !$past(rd_force_i) && $countones(code_o) == 5) |-> (rd_o == $past(rd_o)));

    p_heavy_flips_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !$past(rd_force_i) && $countones(code_o) != 5) |-> (rd_o != $past(rd_o)));

    p_six_ones_from_neg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !$past(rd_force_i) && $countones(code_o) == 6) |-> !$past(rd_o));

    p_gap_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !$past(rd_force_i)) |-> (rd_o == $past(rd_o) && $stable(code_o)));
endmodule

bind tx_8b10b_enc tx_8b10b_enc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_force_i (rd_force_i),
    .code_o     (code_o),
    .valid_o    (valid_o),
    .kerr_o     (kerr_o),
    .rd_o       (rd_o)
);

// File: tb/tx_8b10b_enc_tb.sv
module tx_8b10b_enc_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data = 8'h00;
    logic       ctrl = 1'b0;
    logic       en = 1'b0;
    logic       idle = 1'b0;
    logic       frc = 1'b0;
    logic       rdin = 1'b0;
    logic [9:0] code;
    logic       valid, kerr, rd, rdcas;

    logic [7:0] hd = 8'h00, ld = 8'h00;
    logic       hc = 1'b0, lc = 1'b0, cen = 1'b0;
    logic [9:0] hcode, lcode;
    logic       hval, lval, herr, lerr, hrd, lrd, hcas, lcas;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    tx_8b10b_enc u_dut (
        .clk(clk), .rst_n(rst_n), .data_i(data), .ctrl_i(ctrl), .en_i(en),
        .idle_i(idle), .rd_force_i(frc), .rd_i(rdin), .code_o(code),
        .valid_o(valid), .kerr_o(kerr), .rd_o(rd), .rd_cas_o(rdcas)
    );

    tx_8b10b_enc u_hi (
        .clk(clk), .rst_n(rst_n), .data_i(hd), .ctrl_i(hc), .en_i(cen),
        .idle_i(1'b0), .rd_force_i(1'b1), .rd_i(lrd), .code_o(hcode),
        .valid_o(hval), .kerr_o(herr), .rd_o(hrd), .rd_cas_o(hcas)
    );

    tx_8b10b_enc u_lo (
        .clk(clk), .rst_n(rst_n), .data_i(ld), .ctrl_i(lc), .en_i(cen),
        .idle_i(1'b0), .rd_force_i(1'b1), .rd_i(hcas), .code_o(lcode),
        .valid_o(lval), .kerr_o(lerr), .rd_o(lrd), .rd_cas_o(lcas)
    );

    // transmission string (a first, as MSB) to port order
    function automatic logic [9:0] tx(input logic [9:0] s);
        logic [9:0] r;
        for (int k = 0; k < 10; k++) r[k] = s[9-k];
        return r;
    endfunction

    task automatic chk(input string what, input logic [9:0] act, input logic [9:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    // checks the word on the outputs: code (transmission string), valid, error, rd
    task automatic chk_word(input string what, input logic [9:0] s, input logic e, input logic r);
        chk({what, " code"}, code, tx(s));
        chk({what, " valid"}, {9'd0, valid}, 10'd1);
        chk({what, " kerr"}, {9'd0, kerr}, {9'd0, e});
        chk({what, " rd"}, {9'd0, rd}, {9'd0, r});
    endtask

    // one isolated word; returns at the sample point (third falling edge after drive)
    task automatic send(input logic [7:0] d, input logic c, input logic e, input logic i);
        @(negedge clk); data = d; ctrl = c; en = e; idle = i;
        @(negedge clk); en = 1'b0; idle = 1'b0; ctrl = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11 reset code", code, 10'd0);
        chk("R11 reset valid", {9'd0, valid}, 10'd0);
        chk("R11 reset kerr", {9'd0, kerr}, 10'd0);
        chk("R11 reset rd", {9'd0, rd}, 10'd0);
    endtask

    task automatic t_latency;
        @(negedge clk); data = 8'h00; ctrl = 1'b0; en = 1'b1;
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R8 valid one cycle early", {9'd0, valid}, 10'd0);
        @(negedge clk);
        chk_word("R8 R1 D0.0 neg", 10'b100111_0100, 1'b0, 1'b0);
    endtask

    task automatic t_data;
        send(8'hB5, 1'b0, 1'b1, 1'b0);
        chk_word("R1 D21.5 neutral", 10'b101010_1010, 1'b0, 1'b0);
        @(negedge clk); data = 8'h07; ctrl = 1'b0; en = 1'b1;
        @(negedge clk); en = 1'b0;
        @(negedge clk); #1;
        chk("R10 cascade D7.0 from neg", {9'd0, rdcas}, 10'd1);
        @(negedge clk);
        chk_word("R1 D7.0 neg", 10'b111000_1011, 1'b0, 1'b1);
        send(8'h07, 1'b0, 1'b1, 1'b0);
        chk_word("R1 D7.0 pos", 10'b000111_0100, 1'b0, 1'b0);
    endtask

    task automatic t_alt7;
        send(8'hF1, 1'b0, 1'b1, 1'b0);
        chk_word("R3 D17.7 alternate", 10'b100011_0111, 1'b0, 1'b1);
        send(8'hE3, 1'b0, 1'b1, 1'b0);
        chk_word("R3 D3.7 primary pos", 10'b110001_0001, 1'b0, 1'b0);
    endtask

    task automatic t_kchar;
        send(8'hBC, 1'b1, 1'b1, 1'b0);
        chk_word("R4 K28.5 neg", 10'b001111_1010, 1'b0, 1'b1);
        send(8'hBC, 1'b1, 1'b1, 1'b0);
        chk_word("R4 K28.5 pos", 10'b110000_0101, 1'b0, 1'b0);
        send(8'hFC, 1'b1, 1'b1, 1'b0);
        chk_word("R4 K28.7 neg", 10'b001111_1000, 1'b0, 1'b0);
        send(8'h3C, 1'b1, 1'b1, 1'b0);
        chk_word("R4 K28.1 neg", 10'b001111_1001, 1'b0, 1'b1);
        send(8'hF7, 1'b1, 1'b1, 1'b0);
        chk_word("R4 K23.7 pos", 10'b000101_0111, 1'b0, 1'b1);
        send(8'h1C, 1'b1, 1'b1, 1'b0);
        chk_word("R4 K28.0 pos", 10'b110000_1011, 1'b0, 1'b1);
    endtask

    task automatic t_errcode;
        send(8'hFF, 1'b1, 1'b1, 1'b0);
        chk_word("R6 error code pos", 10'b110000_1110, 1'b0, 1'b1);
        send(8'h3C, 1'b1, 1'b1, 1'b0);
        chk_word("R4 K28.1 pos", 10'b110000_0110, 1'b0, 1'b0);
        send(8'hFF, 1'b1, 1'b1, 1'b0);
        chk_word("R6 error code neg", 10'b001111_0001, 1'b0, 1'b0);
    endtask

    task automatic t_badk;
        send(8'h00, 1'b1, 1'b1, 1'b0);
        chk_word("R5 bad K0.0 neg", 10'b001111_1010, 1'b1, 1'b1);
        send(8'hE3, 1'b1, 1'b1, 1'b0);
        chk_word("R5 bad K3.7 pos", 10'b110000_0101, 1'b1, 1'b0);
    endtask

    task automatic t_idle;
        send(8'h00, 1'b0, 1'b0, 1'b1);
        chk_word("R7 idle fill", 10'b001111_1010, 1'b0, 1'b1);
        send(8'h55, 1'b0, 1'b0, 1'b0);
        chk("R7 gap valid", {9'd0, valid}, 10'd0);
        chk("R7 gap code held", code, tx(10'b001111_1010));
        chk("R7 gap rd held", {9'd0, rd}, 10'd1);
    endtask

    task automatic t_force;
        @(negedge clk); data = 8'h00; ctrl = 1'b0; en = 1'b1;
        @(negedge clk); en = 1'b0;
        @(negedge clk); frc = 1'b1; rdin = 1'b0; #1;
        chk("R10 cascade under force neg", {9'd0, rdcas}, 10'd0);
        @(negedge clk); frc = 1'b0;
        chk_word("R9 force neg D0.0", 10'b100111_0100, 1'b0, 1'b0);
        @(negedge clk); data = 8'h00; ctrl = 1'b0; en = 1'b1;
        @(negedge clk); en = 1'b0;
        @(negedge clk); frc = 1'b1; rdin = 1'b1; #1;
        chk("R10 cascade under force pos", {9'd0, rdcas}, 10'd1);
        @(negedge clk); frc = 1'b0; rdin = 1'b0;
        chk_word("R9 force pos D0.0", 10'b011000_1011, 1'b0, 1'b1);
    endtask

    task automatic t_cascade;
        @(negedge clk); hd = 8'hBC; hc = 1'b1; ld = 8'h00; lc = 1'b0; cen = 1'b1;
        @(negedge clk); hd = 8'hBC; hc = 1'b1; ld = 8'hB5; lc = 1'b0;
        @(negedge clk); cen = 1'b0;
        @(negedge clk);
        chk("R10 pair word1 high", hcode, tx(10'b001111_1010));
        chk("R10 pair word1 low", lcode, tx(10'b011000_1011));
        chk("R10 pair word1 low rd", {9'd0, lrd}, 10'd1);
        @(negedge clk);
        chk("R10 pair word2 high", hcode, tx(10'b110000_0101));
        chk("R10 pair word2 low", lcode, tx(10'b101010_1010));
        chk("R10 pair word2 low rd", {9'd0, lrd}, 10'd0);
    endtask

    task automatic t_sweep;
        logic [9:0] seen [256];
        logic       prev_rd;
        logic       last_bit;
        int         run;
        int         ones;
        int         dups;
        logic       ok;
        run = 0;
        last_bit = 1'b0;
        @(negedge clk);
        prev_rd = rd;
        for (int j = 0; j < 259; j++) begin
            if (j >= 3) begin
                ones = $countones(code);
                ok = valid && (ones >= 4) && (ones <= 6);
                if (ones == 6 && prev_rd) ok = 1'b0;
                if (ones == 4 && !prev_rd) ok = 1'b0;
                if (rd !== (prev_rd ^ (ones != 5))) ok = 1'b0;
                for (int b = 0; b < 10; b++) begin
                    if (run > 0 && code[b] == last_bit) run++;
                    else run = 1;
                    last_bit = code[b];
                    if (run > 5) ok = 1'b0;
                end
                seen[j-3] = code;
                n_tests++;
                if (!ok) begin
                    n_fail++;
                    $display("FAIL R2 R3 sweep byte %0d: actual code %b rd %b expected balanced code from rd %b",
                             j - 3, code, rd, prev_rd);
                end
                prev_rd = rd;
            end
            if (j < 256) begin
                data = j[7:0]; ctrl = 1'b0; en = 1'b1;
            end else begin
                en = 1'b0;
            end
            if (j < 258) @(negedge clk);
        end
        dups = 0;
        for (int a = 0; a < 256; a++)
            for (int b = a + 1; b < 256; b++)
                if (seen[a] == seen[b]) dups++;
        chk("R1 distinct words for all bytes", dups[9:0], 10'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_latency();
        t_data();
        t_alt7();
        t_kchar();
        t_errcode();
        t_badk();
        t_idle();
        t_force();
        t_cascade();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule